// File: doc/BRIEF.md
# Multi-Step Repeated-Subtraction Divider

This block divides one unsigned integer by another by taking the divisor away from the dividend again and again. Each subtraction adds one to the quotient. A three-state controller runs the operation through a start/acknowledge handshake. While idle, the block keeps capturing its operand buses. A start pulse launches the computation. When the result is ready, the block raises a done flag and holds quotient and remainder until the consumer acknowledges them.

To use each clock period fully, the compute state does not perform just one subtraction per cycle. It runs a parameterised cascade of dependent compare-and-subtract stages, and every stage feeds the next within the same cycle. The cascade can stop partway through: a stage whose incoming value has dropped below the divisor passes that value on untouched. The compute phase ends in the first cycle in which the cascade does not use all of its stages. The operand width and the stage count are parameters. Stage counts of 1, 2, 4 and 8 are the supported set.

Top module: `subtract_divider`

## Requirements
- R1: An active-high asynchronous reset forces the controller to the idle state immediately, without waiting for a clock edge. The `state` output reads 2'b00 in idle and `done` is low.
- R2: At every clock edge spent in idle, the block captures `dividend` and `divisor` and clears the quotient. While idle, `remainder` therefore shows the dividend captured at the last edge and `quotient` shows zero.
- R3: If `start` is high at an edge in idle, the next state is compute (`state` = 2'b01). If `start` is low, the block stays idle.
- R4: For a non-zero divisor, the final results satisfy quotient × divisor + remainder = dividend and remainder < divisor.
- R5: Each compute cycle applies up to STAGES chained subtractions. A stage subtracts and adds one to the quotient only when its incoming value is at least the divisor, so no stage ever increases or wraps its value.
- R6: For a non-zero divisor, the number of clock cycles spent in compute equals ceil((quotient + 1) / STAGES). The block leaves compute after the first cycle in which the cascade did not subtract at its last stage.
- R7: In the done state (`state` = 2'b10), `done` is high, and state, quotient and remainder hold for as long as `ack` is low. An edge with `ack` high returns the block to idle.
- R8: A zero divisor spends exactly one cycle in compute. It then reaches done with the quotient all ones and the remainder equal to the dividend.
- R9: The results of R4, R6 and R8 hold for STAGES values of 1, 2, 4 and 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Asynchronous reset, active high |
| start | input | 1 | Launches a division from the idle state |
| ack | input | 1 | Acknowledges the result in the done state |
| dividend | input | WIDTH | Dividend operand, captured in idle |
| divisor | input | WIDTH | Divisor operand, captured in idle |
| quotient | output | WIDTH | Quotient register |
| remainder | output | WIDTH | Working dividend; the remainder once done |
| state | output | 2 | Controller state: 00 idle, 01 compute, 10 done |
| done | output | 1 | High while in the done state |

## Verification
The assertions assume that reset is asserted before the first clock edge. They also assume that the operands are sampled only at an idle edge, so the divisor stays fixed throughout compute and done; the register capture guarantees this whatever the buses do. The stimulus drives operands and `start` together at a falling edge in idle and lowers `start` one cycle later. It raises `ack` only after the done state has been observed and held for an extra cycle. All 256 operand pairs of a 4-bit configuration go to four instances in parallel, one for each supported stage count.

// File: rtl/subdiv_pkg.sv
package subdiv_pkg;

    typedef enum logic [1:0] {
        SD_IDLE = 2'b00,
        SD_RUN  = 2'b01,
        SD_DONE = 2'b10
    } sd_state_e;

    // A stage count is legal if it is a power of two in the range 1 to 8.
    function automatic bit sd_stages_ok(input int n);
        return (n == 1) || (n == 2) || (n == 4) || (n == 8);
    endfunction

endpackage

// File: rtl/subdiv_stage.sv
module subdiv_stage #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] rem_in,
    input  logic [WIDTH-1:0] quo_in,
    input  logic [WIDTH-1:0] dvs,
    output logic [WIDTH-1:0] rem_out,
    output logic [WIDTH-1:0] quo_out,
    output logic             took
);
    localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

    always_comb begin
        took = (rem_in >= dvs);
        if (took) begin
            rem_out = rem_in - dvs;
            quo_out = quo_in + ONE;
        end else begin
            rem_out = rem_in;
            quo_out = quo_in;
        end
    end

    // R5: a stage never raises or wraps the working value
    always_comb begin
        assert_no_underflow_R5: assert (rem_out <= rem_in);
    end

endmodule

// File: rtl/subdiv_chain.sv
module subdiv_chain #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic [WIDTH-1:0] rem_in,
    input  logic [WIDTH-1:0] quo_in,
    input  logic [WIDTH-1:0] dvs,
    output logic [WIDTH-1:0] rem_out,
    output logic [WIDTH-1:0] quo_out,
    output logic             full_use
);
    logic [WIDTH-1:0] rem_w [STAGES+1];
    logic [WIDTH-1:0] quo_w [STAGES+1];
    logic [STAGES-1:0] took_w;

    assign rem_w[0] = rem_in;
    assign quo_w[0] = quo_in;

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        subdiv_stage #(.WIDTH(WIDTH)) u_stage (
            .rem_in (rem_w[k]),
            .quo_in (quo_w[k]),
            .dvs    (dvs),
            .rem_out(rem_w[k+1]),
            .quo_out(quo_w[k+1]),
            .took   (took_w[k])
        );
        if (k > 0) begin : g_order
            // R5: once a stage passes its value through, no later stage subtracts
            always_comb begin
                assert_chain_stops_R5: assert (!((dvs != '0) && !took_w[k-1] && took_w[k]));
            end
        end
    end

    assign rem_out  = rem_w[STAGES];
    assign quo_out  = quo_w[STAGES];
    assign full_use = took_w[STAGES-1];

endmodule

// File: rtl/subdiv_fsm.sv
module subdiv_fsm
    import subdiv_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      ack,
    input  logic      finish,
    output sd_state_e cur
);
    sd_state_e nxt;

    always_comb begin
        nxt = cur;
        unique case (cur)
            SD_IDLE: if (start)  nxt = SD_RUN;
            SD_RUN:  if (finish) nxt = SD_DONE;
            SD_DONE: if (ack)    nxt = SD_IDLE;
            default:             nxt = SD_IDLE;
        endcase
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) cur <= SD_IDLE;
        else     cur <= nxt;
    end

    // R3: start in idle leads to compute
    assert_start_launch_R3: assert property (@(posedge clk) disable iff (rst)
        (cur == SD_IDLE && start) |=> (cur == SD_RUN));

    // R7: done is left only through ack
    assert_done_wait_R7: assert property (@(posedge clk) disable iff (rst)
        (cur == SD_DONE && !ack) |=> (cur == SD_DONE));

    assert_ack_return_R7: assert property (@(posedge clk) disable iff (rst)
        (cur == SD_DONE && ack) |=> (cur == SD_IDLE));

endmodule

// File: rtl/subtract_divider.sv
module subtract_divider
    import subdiv_pkg::*;
#(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             ack,
    input  logic [WIDTH-1:0] dividend,
    input  logic [WIDTH-1:0] divisor,
    output logic [WIDTH-1:0] quotient,
    output logic [WIDTH-1:0] remainder,
    output logic [1:0]       state,
    output logic             done
);
    localparam logic [WIDTH-1:0] ALL_ONES = '1;
    localparam bit STAGES_LEGAL = sd_stages_ok(STAGES);

    sd_state_e        cur;
    logic [WIDTH-1:0] work_q;
    logic [WIDTH-1:0] dvs_q;
    logic [WIDTH-1:0] quo_q;
    logic [WIDTH-1:0] ch_rem;
    logic [WIDTH-1:0] ch_quo;
    logic             ch_full;
    logic             dvs_zero;
    logic             finish;

    initial begin
        assert_stage_count_R9: assert (STAGES_LEGAL);
    end

    subdiv_chain #(.WIDTH(WIDTH), .STAGES(STAGES)) u_chain (
        .rem_in  (work_q),
        .quo_in  (quo_q),
        .dvs     (dvs_q),
        .rem_out (ch_rem),
        .quo_out (ch_quo),
        .full_use(ch_full)
    );

    assign dvs_zero = (dvs_q == '0);
    assign finish   = dvs_zero || !ch_full;

    subdiv_fsm u_fsm (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .ack   (ack),
        .finish(finish),
        .cur   (cur)
    );

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            work_q <= '0;
            dvs_q  <= '0;
            quo_q  <= '0;
        end else begin
            unique case (cur)
                SD_IDLE: begin
                    work_q <= dividend;
                    dvs_q  <= divisor;
                    quo_q  <= '0;
                end
                SD_RUN: begin
                    if (dvs_zero) begin
                        quo_q <= ALL_ONES;
                    end else begin
                        work_q <= ch_rem;
                        quo_q  <= ch_quo;
                    end
                end
                default: ;
            endcase
        end
    end

    assign quotient  = quo_q;
    assign remainder = work_q;
    assign state     = cur;
    assign done      = (cur == SD_DONE);

    // R2: after an idle edge the quotient reads zero
    assert_idle_clear_R2: assert property (@(posedge clk) disable iff (rst)
        (cur == SD_IDLE) |=> (quotient == '0));

    // R4: a finished division with a non-zero divisor leaves a remainder below it
    assert_rem_below_R4: assert property (@(posedge clk) disable iff (rst)
        (cur == SD_DONE && !dvs_zero) |-> (remainder < dvs_q));

    // R5: the quotient only grows while computing
    assert_quo_grows_R5: assert property (@(posedge clk) disable iff (rst)
        (cur == SD_RUN) |=> (quotient >= $past(quotient)));

    // R6: a fully used cascade keeps the block in compute
    assert_keep_running_R6: assert property (@(posedge clk) disable iff (rst)
        (cur == SD_RUN && !dvs_zero && ch_full) |=> (cur == SD_RUN));

    // R7: results stay frozen while waiting for ack
    assert_hold_results_R7: assert property (@(posedge clk) disable iff (rst)
        (cur == SD_DONE && !ack) |=> ($stable(quotient) && $stable(remainder)));

    // R8: a zero divisor finishes after one compute cycle with a saturated quotient
    assert_zero_div_R8: assert property (@(posedge clk) disable iff (rst)
        (cur == SD_RUN && dvs_zero) |=> (cur == SD_DONE && quotient == ALL_ONES));

endmodule

// File: tb/sim_subtract_divider.sv
module sim_subtract_divider;

    localparam int W  = 4;
    localparam int NI = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         ack = 1'b0;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;

    logic [W-1:0] qo [NI];
    logic [W-1:0] ro [NI];
    logic [1:0]   st [NI];
    logic         dn [NI];

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    for (genvar g = 0; g < NI; g++) begin : g_dut
        subtract_divider #(.WIDTH(W), .STAGES(1 << g)) u0 (
            .clk      (clk),
            .rst      (rst),
            .start    (start),
            .ack      (ack),
            .dividend (a),
            .divisor  (b),
            .quotient (qo[g]),
            .remainder(ro[g]),
            .state    (st[g]),
            .done     (dn[g])
        );
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R7 watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int cnt [NI];
        int ea, eb, eq, er, ec, n;
        bit all_done;

        // reset state
        @(negedge clk);
        @(negedge clk);
        for (int k = 0; k < NI; k++) begin
            chk(st[k] == 2'b00, "R1 state after reset", st[k], 0);
            chk(dn[k] == 1'b0, "R1 done after reset", dn[k], 0);
        end
        rst = 1'b0;

        // R2/R3: idle keeps reloading while start is low
        a = 4'd9; b = 4'd2;
        @(negedge clk);
        a = 4'd13;
        @(negedge clk);
        @(negedge clk);
        for (int k = 0; k < NI; k++) begin
            chk(st[k] == 2'b00, "R3 idle without start", st[k], 0);
            chk(ro[k] == 4'd13, "R2 reload dividend", ro[k], 13);
            chk(qo[k] == 4'd0, "R2 quotient cleared", qo[k], 0);
        end

        // R1: asynchronous reset in the middle of compute
        a = 4'd15; b = 4'd1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(st[0] == 2'b01, "R3 entered compute", st[0], 1);
        #2 rst = 1'b1;
        #1;
        for (int k = 0; k < NI; k++)
            chk(st[k] == 2'b00, "R1 async reset without edge", st[k], 0);
        @(negedge clk);
        rst = 1'b0;

        // exhaustive sweep
        for (int ia = 0; ia < 16; ia++) begin
            for (int ib = 0; ib < 16; ib++) begin
                @(negedge clk);
                a = ia[W-1:0]; b = ib[W-1:0]; start = 1'b1;
                ea = ia; eb = ib;
                @(negedge clk);
                start = 1'b0;
                for (int k = 0; k < NI; k++) begin
                    cnt[k] = 0;
                    chk(st[k] == 2'b01, "R3 start to compute", st[k], 1);
                end
                for (int guard = 0; guard < 40; guard++) begin
                    all_done = 1'b1;
                    for (int k = 0; k < NI; k++) begin
                        if (st[k] == 2'b01) cnt[k]++;
                        if (st[k] != 2'b10) all_done = 1'b0;
                    end
                    if (all_done) break;
                    @(negedge clk);
                end
                for (int k = 0; k < NI; k++) begin
                    n = 1 << k;
                    chk(dn[k] == 1'b1 && st[k] == 2'b10, "R7 done state", st[k], 2);
                    if (eb == 0) begin
                        chk(qo[k] == 4'hF, "R8 zero divisor quotient", qo[k], 15);
                        chk(int'(ro[k]) == ea, "R8 zero divisor remainder", ro[k], ea);
                        chk(cnt[k] == 1, "R8 zero divisor cycles", cnt[k], 1);
                    end else begin
                        eq = ea / eb; er = ea % eb;
                        ec = (eq + n) / n;
                        chk(int'(qo[k]) * eb + int'(ro[k]) == ea, "R4 identity", int'(qo[k]) * eb + int'(ro[k]), ea);
                        chk(int'(ro[k]) < eb, "R4 remainder below divisor", ro[k], er);
                        chk(int'(qo[k]) == eq, "R9 quotient per stage count", qo[k], eq);
                        chk(cnt[k] == ec, "R6 compute cycles", cnt[k], ec);
                    end
                end
                // R7: hold while ack stays low
                @(negedge clk);
                for (int k = 0; k < NI; k++) begin
                    chk(st[k] == 2'b10, "R7 hold without ack", st[k], 2);
                    if (eb != 0) begin
                        chk(int'(ro[k]) == ea % eb, "R7 remainder held", ro[k], ea % eb);
                        chk(int'(qo[k]) == ea / eb, "R5 quotient held", qo[k], ea / eb);
                    end
                end
                ack = 1'b1;
                @(negedge clk);
                ack = 1'b0;
                for (int k = 0; k < NI; k++)
                    chk(st[k] == 2'b00, "R7 ack returns idle", st[k], 0);
            end
        end

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule